// File: doc/BRIEF.md
# Dual-Protocol Control Register Port

This block is a slave configuration port holding five 8-bit control registers whose contents are presented in parallel to the rest of the chip. After reset it behaves as a two-wire (I2C) slave on a clock pin and a bidirectional data pin. The same two pins can instead act as a write-only SPI-style port framed by a select pin. That select pin doubles as the low bit of the I2C device address. The first high-to-low edge seen on the select pin after reset moves the port into SPI operation, and it stays there until the next reset.

In both protocols the first byte after the device address is a pointer byte. Its low three bits pick a register and its top bit requests that the pointer step forward after each data byte. Every bus pin is brought into the system clock domain through a two-flop synchroniser. START, STOP and clock edges are all detected on the synchronised copies, so the bus must run several times slower than the system clock.

Top module: `ctlport_regs`

## Requirements
- R1: After reset the register outputs are cfg0=00h, cfg1=83h, cfg2=49h, cfg3=00h and cfg4=00h, the pointer is 00h (increment clear, register 0), and SDA is not driven.
- R2: In two-wire mode the slave acknowledges an address byte only when its upper seven bits equal 0010000 with the last of them replaced by the current level of the select pin (seven-bit address 001000 followed by that level). Bit 0 is the direction (1 = read). A mismatching address is not acknowledged, and the slave stays silent until the next START.
- R3: A write transaction is address (direction 0), pointer byte, then data bytes, sent MSB first. The slave acknowledges each byte by pulling SDA low during the ninth clock, and each data byte is stored in the register the pointer selects.
- R4: Pointer byte bit 7 enables auto-increment, bits 2:0 select the register, and bits 6:3 have no effect. With bit 7 set, the register field advances by one (modulo 8) after every data byte written or read. With it clear, successive data bytes all target the same register.
- R5: A read transaction (direction 1) returns the register at the current pointer, MSB first, with SDA changed only while SCL is low. That pointer is the last one written, or 00h if none was. The slave keeps sending further bytes while the master acknowledges, and stops after the master leaves the ninth bit high.
- R6: Pointer register values 5, 6 and 7 select no register: writes to them change no output, and reads from them return 00h.
- R7: The first falling edge on the select pin after reset permanently selects SPI mode. From then on, two-wire traffic is neither acknowledged nor able to change any register.
- R8: In SPI mode, with the select pin low, bits are taken MSB first on rising SCL edges. The first byte must be 20h, the second is the pointer byte, and every later byte is written as in R3/R4. A wrong first byte causes the rest of that select-low period to be ignored. Raising the select pin ends the transfer.
- R9: A START at any point, including in the middle of a byte, abandons the current transfer and begins a new address phase without writing the partial byte. A STOP returns the slave to idle.
- R10: In SPI mode the block never enables its SDA output driver.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Two-wire clock / SPI bit clock |
| sda_in | input | 1 | Sensed level of the data line (two-wire SDA / SPI data in) |
| sda_out | output | 1 | Level driven on the data line when enabled |
| sda_oe | output | 1 | Output enable for the data line driver |
| sel_in | input | 1 | Two-wire address bit 0 level / SPI select (active low) |
| cfg0 | output | 8 | Register 0 contents |
| cfg1 | output | 8 | Register 1 contents |
| cfg2 | output | 8 | Register 2 contents |
| cfg3 | output | 8 | Register 3 contents |
| cfg4 | output | 8 | Register 4 contents |

## Verification
The bench sweeps every pointer value from 0 to 7 with single-byte writes and read-backs, using data bytes derived from the pointer. This separates the five real registers from the three unmapped slots, and it exposes any aliasing between address bits. Bursts are run with the increment bit set and with it clear. Their results tell stepping apart from overwriting, and a reserved-bit pattern in the pointer shows that those bits are ignored. Addresses are tried with the select level both matching and not matching, and a START is issued in the middle of a byte. The run ends in SPI mode with a correct frame, a frame with a bad first byte, and a two-wire write that must be rejected, while a monitor watches the output enable throughout.

// File: rtl/ctlport_regs.sv
module ctlport_regs #(
  parameter logic [5:0] DEV_BASE = 6'b001000,
  parameter logic [7:0] RST0 = 8'h00,
  parameter logic [7:0] RST1 = 8'h83,
  parameter logic [7:0] RST2 = 8'h49,
  parameter logic [7:0] RST3 = 8'h00,
  parameter logic [7:0] RST4 = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_out,
  output logic       sda_oe,
  input  logic       sel_in,
  output logic [7:0] cfg0,
  output logic [7:0] cfg1,
  output logic [7:0] cfg2,
  output logic [7:0] cfg3,
  output logic [7:0] cfg4
);
  localparam int NREG = 5;
  localparam logic [7:0] SPI_HDR = {DEV_BASE, 2'b00};

  typedef enum logic [2:0] {I_IDLE, I_ADDR, I_PTR, I_WR, I_RD} ist_t;

  logic [2:0] scl_sr, sda_sr, sel_sr;
  logic       scl_s, scl_d, sda_s, sda_d, sel_s, sel_d;
  logic       scl_rise, scl_fall, start_c, stop_c, sel_fall;

  logic [7:0] bank [NREG];
  logic       ptr_inc;
  logic [2:0] ptr_addr;
  logic       spi_mode;
  ist_t       istate, nstate;
  logic [3:0] bitcnt;
  logic [6:0] shreg;
  logic       ack_pend;
  logic [7:0] txbyte;
  logic       sda_oe_q, sda_out_q;
  logic [2:0] sbit;
  logic [1:0] sstage;
  logic       sbad;
  logic [7:0] rx_byte, rd_byte;

  assign scl_s = scl_sr[1];
  assign scl_d = scl_sr[2];
  assign sda_s = sda_sr[1];
  assign sda_d = sda_sr[2];
  assign sel_s = sel_sr[1];
  assign sel_d = sel_sr[2];

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & ~sda_s & sda_d;
  assign stop_c   = scl_s & scl_d & sda_s & ~sda_d;
  assign sel_fall = ~sel_s & sel_d;

  assign rx_byte = {shreg, sda_s};
  assign rd_byte = (ptr_addr < 3'(NREG)) ? bank[ptr_addr] : 8'h00;

  assign sda_oe  = sda_oe_q;
  assign sda_out = sda_out_q;
  assign cfg0 = bank[0];
  assign cfg1 = bank[1];
  assign cfg2 = bank[2];
  assign cfg3 = bank[3];
  assign cfg4 = bank[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr    <= '1;
      sda_sr    <= '1;
      sel_sr    <= '0;
      bank[0]   <= RST0;
      bank[1]   <= RST1;
      bank[2]   <= RST2;
      bank[3]   <= RST3;
      bank[4]   <= RST4;
      ptr_inc   <= 1'b0;
      ptr_addr  <= 3'd0;
      spi_mode  <= 1'b0;
      istate    <= I_IDLE;
      nstate    <= I_IDLE;
      bitcnt    <= 4'd0;
      shreg     <= 7'd0;
      ack_pend  <= 1'b0;
      txbyte    <= 8'h00;
      sda_oe_q  <= 1'b0;
      sda_out_q <= 1'b1;
      sbit      <= 3'd0;
      sstage    <= 2'd0;
      sbad      <= 1'b0;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_in};
      sda_sr <= {sda_sr[1:0], sda_in};
      sel_sr <= {sel_sr[1:0], sel_in};

      if (!spi_mode) begin
        if (sel_fall) begin
          spi_mode <= 1'b1;
          istate   <= I_IDLE;
          ack_pend <= 1'b0;
          sda_oe_q <= 1'b0;
        end else if (start_c) begin
          istate   <= I_ADDR;
          bitcnt   <= 4'd0;
          ack_pend <= 1'b0;
          sda_oe_q <= 1'b0;
        end else if (stop_c) begin
          istate   <= I_IDLE;
          ack_pend <= 1'b0;
          sda_oe_q <= 1'b0;
        end else if (scl_rise && istate != I_IDLE) begin
          if (bitcnt == 4'd8) begin
            bitcnt   <= 4'd0;
            ack_pend <= 1'b0;
            if (istate == I_RD) begin
              if (sda_s) istate <= I_IDLE;
              else txbyte <= rd_byte;
            end else begin
              istate <= nstate;
              if (nstate == I_RD) txbyte <= rd_byte;
            end
          end else begin
            bitcnt <= bitcnt + 4'd1;
            shreg  <= rx_byte[6:0];
            if (bitcnt == 4'd7) begin
              case (istate)
                I_ADDR: begin
                  if (rx_byte[7:1] == {DEV_BASE, sel_s}) begin
                    ack_pend <= 1'b1;
                    nstate   <= rx_byte[0] ? I_RD : I_PTR;
                  end else begin
                    istate <= I_IDLE;
                  end
                end
                I_PTR: begin
                  ptr_inc  <= rx_byte[7];
                  ptr_addr <= rx_byte[2:0];
                  ack_pend <= 1'b1;
                  nstate   <= I_WR;
                end
                I_WR: begin
                  if (ptr_addr < 3'(NREG)) bank[ptr_addr] <= rx_byte;
                  if (ptr_inc) ptr_addr <= ptr_addr + 3'd1;
                  ack_pend <= 1'b1;
                  nstate   <= I_WR;
                end
                I_RD: begin
                  if (ptr_inc) ptr_addr <= ptr_addr + 3'd1;
                end
                default: ;
              endcase
            end
          end
        end else if (scl_fall) begin
          if (istate == I_RD && bitcnt < 4'd8) begin
            sda_oe_q  <= 1'b1;
            sda_out_q <= txbyte[~bitcnt[2:0]];
          end else if (bitcnt == 4'd8 && ack_pend) begin
            sda_oe_q  <= 1'b1;
            sda_out_q <= 1'b0;
          end else begin
            sda_oe_q  <= 1'b0;
          end
        end
      end else begin
        sda_oe_q <= 1'b0;
        if (sel_s) begin
          sbit   <= 3'd0;
          sstage <= 2'd0;
          sbad   <= 1'b0;
        end else if (scl_rise && !sbad) begin
          sbit  <= sbit + 3'd1;
          shreg <= rx_byte[6:0];
          if (sbit == 3'd7) begin
            case (sstage)
              2'd0: begin
                if (rx_byte == SPI_HDR) sstage <= 2'd1;
                else sbad <= 1'b1;
              end
              2'd1: begin
                ptr_inc  <= rx_byte[7];
                ptr_addr <= rx_byte[2:0];
                sstage   <= 2'd2;
              end
              default: begin
                if (ptr_addr < 3'(NREG)) bank[ptr_addr] <= rx_byte;
                if (ptr_inc) ptr_addr <= ptr_addr + 3'd1;
              end
            endcase
          end
        end
      end
    end
  end

  AST_SPI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> spi_mode); // R7
  AST_SPI_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_mode) |-> $past(sel_fall)); // R7
  AST_SPI_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |-> !sda_oe); // R10
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (istate == I_IDLE) |-> !sda_oe); // R2
  AST_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && istate != I_RD) |-> !sda_out); // R3
  AST_OE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_q) |-> $past(scl_fall || start_c || stop_c || sel_fall)); // R5

endmodule

// File: tb/ctlport_regs_bench.sv
module ctlport_regs_bench;
  localparam int T = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sel_m = 1'b0;
  logic sda_out, sda_oe, sda_bus;
  logic [7:0] cfg0, cfg1, cfg2, cfg3, cfg4;

  int checks = 0;
  int errors = 0;
  int oe_in_spi = 0;
  logic spi_phase = 1'b0;
  logic [7:0] expv [8];

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & (sda_oe ? sda_out : 1'b1);

  ctlport_regs u_ctlport_regs (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_out(sda_out), .sda_oe(sda_oe), .sel_in(sel_m),
    .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2), .cfg3(cfg3), .cfg4(cfg4)
  );

  always @(negedge clk) if (spi_phase && sda_oe) oe_in_spi++;

  task automatic chk(input logic ok, input string req, input int act, input int expd);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expd);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    if (!scl_m) begin
      hw(T); sda_m = 1'b1; hw(T); scl_m = 1'b1; hw(T);
    end
    sda_m = 1'b0; hw(T); scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    hw(T); sda_m = 1'b0; hw(T); scl_m = 1'b1; hw(T); sda_m = 1'b1; hw(2*T);
  endtask

  task automatic bit_clk(input logic b, output logic seen);
    hw(T); sda_m = b; hw(T); scl_m = 1'b1; hw(T); seen = sda_bus; hw(T); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
    bit_clk(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, s);
      b[i] = s;
    end
    bit_clk(!mack, s);
  endtask

  function automatic logic [7:0] addr_byte(input logic lvl, input logic rd);
    return {6'b001000, lvl, rd};
  endfunction

  function automatic logic [7:0] pat(input int p, input int k);
    return 8'(p * 53 + k * 29 + 7);
  endfunction

  function automatic int cfg_of(input int i);
    case (i)
      0: return int'(cfg0);
      1: return int'(cfg1);
      2: return int'(cfg2);
      3: return int'(cfg3);
      default: return int'(cfg4);
    endcase
  endfunction

  task automatic wr1(input logic lvl, input logic [7:0] ptr, input logic [7:0] d);
    logic a0, a1, a2;
    i2c_start(); send_byte(addr_byte(lvl, 1'b0), a0); send_byte(ptr, a1); send_byte(d, a2); i2c_stop();
    chk(a0 && a1 && a2, "R3 write acks", {a0, a1, a2}, 7);
  endtask

  task automatic rd1(input logic lvl, input logic [7:0] ptr, output logic [7:0] d);
    logic a0, a1, a2;
    i2c_start(); send_byte(addr_byte(lvl, 1'b0), a0); send_byte(ptr, a1);
    i2c_start(); send_byte(addr_byte(lvl, 1'b1), a2); recv_byte(1'b0, d); i2c_stop();
    chk(a0 && a1 && a2, "R5 read acks", {a0, a1, a2}, 7);
  endtask

  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hw(T); sda_m = b[i]; hw(T); scl_m = 1'b1; hw(T); scl_m = 1'b0;
    end
  endtask

  initial begin
    hw(150000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack, a1, a2;
    logic [7:0] d;
    logic [7:0] rb [4];
    expv[0] = 8'h00; expv[1] = 8'h83; expv[2] = 8'h49; expv[3] = 8'h00;
    expv[4] = 8'h00; expv[5] = 8'h00; expv[6] = 8'h00; expv[7] = 8'h00;
    hw(4);
    rst_n = 1'b1;
    hw(4);

    // R1 reset state
    for (int i = 0; i < 5; i++) chk(cfg_of(i) == int'(expv[i]), "R1 reset value", cfg_of(i), int'(expv[i]));
    chk(!sda_oe, "R1 sda idle", int'(sda_oe), 0);

    // R1 / R5: read with no prior write uses pointer 00h
    i2c_start(); send_byte(addr_byte(1'b0, 1'b1), ack); recv_byte(1'b0, d); i2c_stop();
    chk(ack, "R2 address ack read", int'(ack), 1);
    chk(d == expv[0], "R1 default pointer read", int'(d), int'(expv[0]));

    // R2 mismatching addresses
    i2c_start(); send_byte(8'h22, ack); i2c_stop();
    chk(!ack, "R2 wrong address nak", int'(ack), 0);
    i2c_start(); send_byte(addr_byte(1'b1, 1'b0), ack); i2c_stop();
    chk(!ack, "R2 select level mismatch nak", int'(ack), 0);
    sel_m = 1'b1;
    hw(2*T);
    i2c_start(); send_byte(addr_byte(1'b0, 1'b0), ack); i2c_stop();
    chk(!ack, "R2 select level mismatch nak high", int'(ack), 0);

    // R3 R6 sweep of all pointer values
    for (int p = 0; p < 8; p++) begin
      wr1(1'b1, 8'(p), pat(p, 1));
      if (p < 5) expv[p] = pat(p, 1);
    end
    for (int p = 0; p < 5; p++) chk(cfg_of(p) == int'(expv[p]), "R3 register output", cfg_of(p), int'(expv[p]));
    for (int p = 0; p < 8; p++) begin
      rd1(1'b1, 8'(p), d);
      chk(d == expv[p], p < 5 ? "R5 read back" : "R6 unmapped read zero", int'(d), int'(expv[p]));
    end

    // R4 increment burst from 0 over all registers
    i2c_start(); send_byte(addr_byte(1'b1, 1'b0), ack); send_byte(8'h80, ack);
    for (int k = 0; k < 5; k++) begin
      send_byte(pat(k, 2), ack);
      expv[k] = pat(k, 2);
    end
    i2c_stop();
    for (int p = 0; p < 5; p++) chk(cfg_of(p) == int'(expv[p]), "R4 increment burst", cfg_of(p), int'(expv[p]));

    // R4 reserved bits ignored, increment from 2
    i2c_start(); send_byte(addr_byte(1'b1, 1'b0), ack); send_byte(8'hFA, ack);
    send_byte(8'hC3, ack); send_byte(8'h3C, ack); i2c_stop();
    expv[2] = 8'hC3; expv[3] = 8'h3C;
    chk(cfg2 == 8'hC3, "R4 reserved pointer bits", int'(cfg2), 8'hC3);
    chk(cfg3 == 8'h3C, "R4 reserved pointer bits step", int'(cfg3), 8'h3C);

    // R4 fixed pointer burst
    i2c_start(); send_byte(addr_byte(1'b1, 1'b0), ack); send_byte(8'h03, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack); i2c_stop();
    expv[3] = 8'h33;
    chk(cfg3 == 8'h33, "R4 fixed pointer last byte", int'(cfg3), 8'h33);
    chk(cfg4 == expv[4], "R4 fixed pointer neighbour unchanged", int'(cfg4), int'(expv[4]));

    // R5 R4 read burst with increment from 1, then pointer at 5
    i2c_start(); send_byte(addr_byte(1'b1, 1'b0), a1); send_byte(8'h81, ack);
    i2c_start(); send_byte(addr_byte(1'b1, 1'b1), a2);
    for (int k = 0; k < 4; k++) recv_byte(k < 3, rb[k]);
    i2c_stop();
    for (int k = 0; k < 4; k++) chk(rb[k] == expv[k+1], "R5 read burst", int'(rb[k]), int'(expv[k+1]));
    i2c_start(); send_byte(addr_byte(1'b1, 1'b1), ack); recv_byte(1'b0, d); i2c_stop();
    chk(d == 8'h00, "R6 read after burst lands on 5", int'(d), 0);

    // R9 START in the middle of a data byte
    i2c_start(); send_byte(addr_byte(1'b1, 1'b0), ack); send_byte(8'h02, ack);
    bit_clk(1'b0, a1); bit_clk(1'b1, a1); bit_clk(1'b0, a1);
    i2c_start(); send_byte(addr_byte(1'b1, 1'b1), ack); recv_byte(1'b0, d); i2c_stop();
    chk(ack, "R9 repeated start address ack", int'(ack), 1);
    chk(d == expv[2], "R9 partial byte not written", int'(d), int'(expv[2]));
    chk(cfg2 == expv[2], "R9 output unchanged", int'(cfg2), int'(expv[2]));

    // R7 R8 switch to SPI
    hw(T); scl_m = 1'b0; hw(T);
    sel_m = 1'b0; spi_phase = 1'b1; hw(2*T);
    spi_byte(8'h20); spi_byte(8'h81); spi_byte(8'hA5); spi_byte(8'h5A);
    hw(T); sel_m = 1'b1; hw(2*T);
    expv[1] = 8'hA5; expv[2] = 8'h5A;
    chk(cfg1 == 8'hA5, "R8 spi write first", int'(cfg1), 8'hA5);
    chk(cfg2 == 8'h5A, "R8 spi write increment", int'(cfg2), 8'h5A);

    sel_m = 1'b0; hw(2*T);
    spi_byte(8'h21); spi_byte(8'h00); spi_byte(8'hEE);
    hw(T); sel_m = 1'b1; hw(2*T);
    chk(cfg0 == expv[0], "R8 bad header ignored", int'(cfg0), int'(expv[0]));

    sel_m = 1'b0; hw(2*T);
    spi_byte(8'h20); spi_byte(8'h04); spi_byte(8'h77); spi_byte(8'h66);
    hw(T); sel_m = 1'b1; hw(2*T);
    expv[4] = 8'h66;
    chk(cfg4 == 8'h66, "R8 spi fixed pointer", int'(cfg4), 8'h66);

    // R7 two-wire traffic now rejected
    i2c_start(); send_byte(addr_byte(1'b1, 1'b0), ack); send_byte(8'h00, a1); send_byte(8'hF0, a2); i2c_stop();
    chk(!ack, "R7 two-wire ignored in spi mode", int'(ack), 0);
    chk(cfg0 == expv[0], "R7 register untouched", int'(cfg0), int'(expv[0]));
    chk(oe_in_spi == 0, "R10 no drive in spi mode", oe_in_spi, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule